// File: doc/BRIEF.md
# Wide Register Write Collector and Read Shadow

This block is the bus interface between a host port and a bank of 128-bit control registers, 64-bit table entries and a few 32-bit doorbells. The host moves at most 64 bits per access, so one wide register takes several accesses to write. The lower pieces of a wide write are held in a single collector shared by all registers. When the top dword arrives, the whole register is written in one cycle, so the register never holds a value that is half old and half new.

Reads work the other way round. Reading dword 0 of a wide register copies the whole live value into a read shadow. The remaining dwords are then served from that copy, so all pieces of one read come from the same instant. Three doorbells per page (an event-queue read pointer and the receive and transmit descriptor-update registers) take a single 32-bit write directly. A doorbell write never touches the collector, so it can be issued in the middle of a wide write.

The address space is split into pages of 0x2000 bytes. Each page holds its own copy of the wide registers and doorbells. The table lives in page 0 only. Every committed write raises a one-cycle strobe for its target.

Top module: `wide_reg_biu`

## Requirements
- R1: After reset, every register, table entry, doorbell, collector slot and the shadow hold zero. `rsp_valid_o` and all strobes are low.
- R2: A 32-bit write to dword 0, 1 or 2 (byte offsets 0, 4, 8) of a wide register only loads the matching collector slot. The register keeps its value and no strobe fires.
- R3: A write of the top dword commits all 128 bits at once, using the collector slots for the lower dwords. The top dword is either a 32-bit write at offset 12 or a 64-bit write at offset 8, whose data fills dwords 2 and 3. On the cycle after the handshake the new value is readable and `wide_commit_o` bit `page*NUM_WIDE+i` is high for one cycle.
- R4: A 64-bit write at offset 0 of a wide register loads collector slots 0 (low half) and 1 (high half) and commits nothing.
- R5: There is one collector for all targets. A top-dword commit uses whatever the slots hold, even if another register or a table dword wrote them. A table lower-dword write uses slot 0.
- R6: A read at offset 0 of a wide register returns the live dwords (dword 0, or dwords 0 and 1 for 64 bits) and loads the full live value into the shadow. Reads at offsets 4, 8 and 12 (and the 64-bit read at 8) return shadow bits, not live bits.
- R7: A doorbell sits at page offsets 0x800, 0x810 and 0x820 (index `page*3+j`). A 32-bit write there shows on `db_value_o[32*idx +: 32]` and pulses `db_strobe_o[idx]` on the next cycle. The collector is left unchanged.
- R8: A 32-bit doorbell read returns its live value and leaves the shadow unchanged.
- R9: Table entry i sits at page-0 offset 0x1000+8*i. It is written by one 64-bit write, or by a dword at +0 (collected into slot 0) followed by a dword at +4 that commits the entry. `tbl_commit_o[i]` pulses the cycle after the commit.
- R10: A table read at +0 (either size) returns the live entry and loads the shadow with the entry in bits 63:0 and zeros above. A read at +4 returns shadow bits 63:32.
- R11: Address = page*0x2000 + offset, with wide register i of each page at offset 16*i.
- R12: These accesses are ignored: misaligned addresses, 64-bit accesses at an odd dword, 64-bit doorbell accesses, and any address outside the map. No state changes and no strobe fires; such a read returns zero.
- R13: `req_ready_o` is always high. A read gets `rsp_valid_o` on the next cycle, with 32-bit read data zero-extended to 64 bits. A write never raises `rsp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size64_i | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_addr_i | input | ADDR_W (14) | Byte address |
| req_wdata_i | input | 64 | Write data (32-bit writes use bits 31:0) |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| wide_commit_o | output | NUM_PAGES*NUM_WIDE (8) | Wide register commit strobes |
| tbl_commit_o | output | TBL_DEPTH (16) | Table entry commit strobes |
| db_strobe_o | output | NUM_PAGES*3 (6) | Doorbell write strobes |
| db_value_o | output | NUM_PAGES*3*32 (192) | Live doorbell values |

## Verification
Wide registers are written three ways: dword by dword, qword by qword, and with mixed sizes. Checking the strobes after every piece shows whether a commit happens only on the top dword. A doorbell write is placed inside an unfinished wide write, which separates a collector that is left alone from one that is flushed or overwritten. Another register is rewritten between the dword-0 read and the later dword reads, which separates shadow data from live data. A constrained-random mix of all targets, both sizes and unmapped addresses is compared against a bench model after every access.

// File: rtl/biu_pkg.sv
package biu_pkg;
  localparam int unsigned DWORD_W  = 32;
  localparam int unsigned QWORD_W  = 64;
  localparam int unsigned OWORD_W  = 128;
  localparam int unsigned PAGE_LSB = 13;        // page block = 0x2000 bytes
  localparam int unsigned DB_BASE  = 32'h800;
  localparam int unsigned DB_COUNT = 3;
  localparam int unsigned TBL_BASE = 32'h1000;

  typedef enum logic [1:0] {K_NONE, K_WIDE, K_TBL, K_DB} kind_e;

  function automatic int unsigned clog2_min1(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/biu_decode.sv
module biu_decode import biu_pkg::*; #(
  parameter int unsigned NUM_PAGES = 2,
  parameter int unsigned NUM_WIDE  = 4,
  parameter int unsigned TBL_DEPTH = 16,
  localparam int unsigned PG_W   = clog2_min1(NUM_PAGES),
  localparam int unsigned ADDR_W = PAGE_LSB + PG_W,
  localparam int unsigned WIDX_W = clog2_min1(NUM_PAGES * NUM_WIDE),
  localparam int unsigned TIDX_W = clog2_min1(TBL_DEPTH),
  localparam int unsigned DIDX_W = clog2_min1(NUM_PAGES * DB_COUNT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size64_i,
  output kind_e             kind_o,
  output logic [1:0]        dw_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic [TIDX_W-1:0] tidx_o,
  output logic [DIDX_W-1:0] didx_o
);
  logic [PAGE_LSB-1:0] off;
  logic [PG_W-1:0]     pg;
  int unsigned         off_u, pg_u;

  assign off   = addr_i[PAGE_LSB-1:0];
  assign pg    = addr_i[ADDR_W-1:PAGE_LSB];
  assign off_u = 32'(off);
  assign pg_u  = 32'(pg);

  always_comb begin
    kind_o = K_NONE;
    dw_o   = '0;
    widx_o = '0;
    tidx_o = '0;
    didx_o = '0;
    if (addr_i[1:0] == 2'b00 && pg_u < NUM_PAGES) begin
      if (off_u < NUM_WIDE * 16) begin
        if (!(size64_i && off[2])) begin
          kind_o = K_WIDE;
          dw_o   = off[3:2];
          widx_o = WIDX_W'(pg_u * NUM_WIDE + (off_u >> 4));
        end
      end else if (off_u >= DB_BASE && off_u < DB_BASE + 16 * DB_COUNT) begin
        if (off[3:0] == 4'h0 && !size64_i) begin
          kind_o = K_DB;
          didx_o = DIDX_W'(pg_u * DB_COUNT + ((off_u - DB_BASE) >> 4));
        end
      end else if (pg_u == 0 && off_u >= TBL_BASE && off_u < TBL_BASE + 8 * TBL_DEPTH) begin
        if (!(size64_i && off[2])) begin
          kind_o = K_TBL;
          dw_o   = {1'b0, off[2]};
          tidx_o = TIDX_W'((off_u - TBL_BASE) >> 3);
        end
      end
    end
  end
endmodule

// File: rtl/biu_collector.sv
module biu_collector import biu_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  kind_e              kind_i,
  input  logic               size64_i,
  input  logic [1:0]         dw_i,
  input  logic [QWORD_W-1:0] wdata_i,
  output logic               wide_we_o,
  output logic [OWORD_W-1:0] wide_wdata_o,
  output logic               tbl_we_o,
  output logic [QWORD_W-1:0] tbl_wdata_o,
  output logic               db_we_o,
  output logic [DWORD_W-1:0] db_wdata_o
);
  logic [2:0][DWORD_W-1:0] col_q, col_d;
  logic [DWORD_W-1:0]      lo_w, hi_w;

  assign lo_w = wdata_i[DWORD_W-1:0];
  assign hi_w = wdata_i[QWORD_W-1:DWORD_W];

  always_comb begin
    col_d        = col_q;
    wide_we_o    = 1'b0;
    tbl_we_o     = 1'b0;
    db_we_o      = 1'b0;
    wide_wdata_o = size64_i ? {hi_w, lo_w, col_q[1], col_q[0]}
                            : {lo_w, col_q[2], col_q[1], col_q[0]};
    tbl_wdata_o  = size64_i ? wdata_i : {lo_w, col_q[0]};
    db_wdata_o   = lo_w;
    if (wr_i) begin
      case (kind_i)
        K_WIDE: begin
          if (size64_i) begin
            if (dw_i == 2'd0) begin
              col_d[0] = lo_w;
              col_d[1] = hi_w;
            end else begin
              wide_we_o = 1'b1;
            end
          end else if (dw_i == 2'd3) begin
            wide_we_o = 1'b1;
          end else begin
            case (dw_i)
              2'd0:    col_d[0] = lo_w;
              2'd1:    col_d[1] = lo_w;
              default: col_d[2] = lo_w;
            endcase
          end
        end
        K_TBL: begin
          if (size64_i || dw_i[0]) tbl_we_o = 1'b1;
          else                     col_d[0] = lo_w;
        end
        K_DB:    db_we_o = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= '0;
    else         col_q <= col_d;
  end

  // R7
  db_keeps_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_DB) |=> $stable(col_q));

  // R2
  partial_holds_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_WIDE && !size64_i && dw_i == 2'd1) |=> (col_q[1] == $past(lo_w)));
endmodule

// File: rtl/biu_regfile.sv
module biu_regfile import biu_pkg::*; #(
  parameter int unsigned NW = 8,
  parameter int unsigned NT = 16,
  parameter int unsigned ND = 6,
  localparam int unsigned WIDX_W = clog2_min1(NW),
  localparam int unsigned TIDX_W = clog2_min1(NT),
  localparam int unsigned DIDX_W = clog2_min1(ND)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wide_we_i,
  input  logic [WIDX_W-1:0]     widx_i,
  input  logic [OWORD_W-1:0]    wide_wdata_i,
  input  logic                  tbl_we_i,
  input  logic [TIDX_W-1:0]     tidx_i,
  input  logic [QWORD_W-1:0]    tbl_wdata_i,
  input  logic                  db_we_i,
  input  logic [DIDX_W-1:0]     didx_i,
  input  logic [DWORD_W-1:0]    db_wdata_i,
  output logic [OWORD_W-1:0]    live_wide_o,
  output logic [QWORD_W-1:0]    live_tbl_o,
  output logic [DWORD_W-1:0]    live_db_o,
  output logic [NW-1:0]         wide_commit_o,
  output logic [NT-1:0]         tbl_commit_o,
  output logic [ND-1:0]         db_strobe_o,
  output logic [ND*DWORD_W-1:0] db_value_o
);
  logic [OWORD_W-1:0] wide_q [NW];
  logic [QWORD_W-1:0] tbl_q  [NT];
  logic [DWORD_W-1:0] db_q   [ND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) wide_q[i] <= '0;
      for (int i = 0; i < NT; i++) tbl_q[i]  <= '0;
      for (int i = 0; i < ND; i++) db_q[i]   <= '0;
      wide_commit_o <= '0;
      tbl_commit_o  <= '0;
      db_strobe_o   <= '0;
    end else begin
      if (wide_we_i) wide_q[widx_i] <= wide_wdata_i;
      if (tbl_we_i)  tbl_q[tidx_i]  <= tbl_wdata_i;
      if (db_we_i)   db_q[didx_i]   <= db_wdata_i;
      wide_commit_o <= wide_we_i ? (NW'(1) << widx_i) : '0;
      tbl_commit_o  <= tbl_we_i  ? (NT'(1) << tidx_i) : '0;
      db_strobe_o   <= db_we_i   ? (ND'(1) << didx_i) : '0;
    end
  end

  assign live_wide_o = wide_q[widx_i];
  assign live_tbl_o  = tbl_q[tidx_i];
  assign live_db_o   = db_q[didx_i];

  for (genvar g = 0; g < ND; g++) begin : g_db_out
    assign db_value_o[g*DWORD_W +: DWORD_W] = db_q[g];
  end

  // R3
  single_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wide_commit_o, tbl_commit_o, db_strobe_o}));

  // R7
  db_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_we_i |=> (db_q[$past(didx_i)] == $past(db_wdata_i)));
endmodule

// File: rtl/biu_readback.sv
module biu_readback import biu_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  kind_e              kind_i,
  input  logic               size64_i,
  input  logic [1:0]         dw_i,
  input  logic [OWORD_W-1:0] live_wide_i,
  input  logic [QWORD_W-1:0] live_tbl_i,
  input  logic [DWORD_W-1:0] live_db_i,
  output logic               rsp_valid_o,
  output logic [QWORD_W-1:0] rsp_rdata_o
);
  localparam int unsigned PAD_W = QWORD_W - DWORD_W;

  logic [OWORD_W-1:0] shadow_q, shadow_d;
  logic [QWORD_W-1:0] rd_d;
  logic               cap;

  always_comb begin
    cap      = 1'b0;
    shadow_d = shadow_q;
    rd_d     = '0;
    case (kind_i)
      K_WIDE: begin
        case (dw_i)
          2'd0: begin
            cap      = 1'b1;
            shadow_d = live_wide_i;
            rd_d     = size64_i ? live_wide_i[QWORD_W-1:0]
                                : {{PAD_W{1'b0}}, live_wide_i[DWORD_W-1:0]};
          end
          2'd1: rd_d = {{PAD_W{1'b0}}, shadow_q[63:32]};
          2'd2: rd_d = size64_i ? shadow_q[127:64] : {{PAD_W{1'b0}}, shadow_q[95:64]};
          default: rd_d = {{PAD_W{1'b0}}, shadow_q[127:96]};
        endcase
      end
      K_TBL: begin
        if (dw_i[0]) begin
          rd_d = {{PAD_W{1'b0}}, shadow_q[63:32]};
        end else begin
          cap      = 1'b1;
          shadow_d = {{(OWORD_W-QWORD_W){1'b0}}, live_tbl_i};
          rd_d     = size64_i ? live_tbl_i : {{PAD_W{1'b0}}, live_tbl_i[DWORD_W-1:0]};
        end
      end
      K_DB:    rd_d = {{PAD_W{1'b0}}, live_db_i};
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q    <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_i;
      if (rd_i) begin
        rsp_rdata_o <= rd_d;
        if (cap) shadow_q <= shadow_d;
      end
    end
  end

  // R13
  rsp_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rsp_valid_o);

  // R13
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rsp_valid_o);

  // R8
  db_rd_keeps_shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && kind_i == K_DB) |=> $stable(shadow_q));

  // R12
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && kind_i == K_NONE) |=> (rsp_rdata_o == '0));
endmodule

// File: rtl/wide_reg_biu.sv
module wide_reg_biu import biu_pkg::*; #(
  parameter int unsigned NUM_PAGES = 2,
  parameter int unsigned NUM_WIDE  = 4,
  parameter int unsigned TBL_DEPTH = 16,
  localparam int unsigned ADDR_W = PAGE_LSB + clog2_min1(NUM_PAGES),
  localparam int unsigned NW     = NUM_PAGES * NUM_WIDE,
  localparam int unsigned ND     = NUM_PAGES * DB_COUNT,
  localparam int unsigned WIDX_W = clog2_min1(NW),
  localparam int unsigned TIDX_W = clog2_min1(TBL_DEPTH),
  localparam int unsigned DIDX_W = clog2_min1(ND)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic                  req_size64_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [QWORD_W-1:0]    req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [QWORD_W-1:0]    rsp_rdata_o,
  output logic [NW-1:0]         wide_commit_o,
  output logic [TBL_DEPTH-1:0]  tbl_commit_o,
  output logic [ND-1:0]         db_strobe_o,
  output logic [ND*DWORD_W-1:0] db_value_o
);
  kind_e              kind;
  logic [1:0]         dw;
  logic [WIDX_W-1:0]  widx;
  logic [TIDX_W-1:0]  tidx;
  logic [DIDX_W-1:0]  didx;
  logic               wr, rd;
  logic               wide_we, tbl_we, db_we;
  logic [OWORD_W-1:0] wide_wdata, live_wide;
  logic [QWORD_W-1:0] tbl_wdata, live_tbl;
  logic [DWORD_W-1:0] db_wdata, live_db;

  assign req_ready_o = 1'b1;
  assign wr = req_valid_i &  req_write_i;
  assign rd = req_valid_i & ~req_write_i;

  biu_decode #(.NUM_PAGES(NUM_PAGES), .NUM_WIDE(NUM_WIDE), .TBL_DEPTH(TBL_DEPTH)) i_decode (
    .addr_i(req_addr_i), .size64_i(req_size64_i), .kind_o(kind), .dw_o(dw),
    .widx_o(widx), .tidx_o(tidx), .didx_o(didx)
  );

  biu_collector i_collector (
    .clk_i, .rst_ni, .wr_i(wr), .kind_i(kind), .size64_i(req_size64_i), .dw_i(dw),
    .wdata_i(req_wdata_i), .wide_we_o(wide_we), .wide_wdata_o(wide_wdata),
    .tbl_we_o(tbl_we), .tbl_wdata_o(tbl_wdata), .db_we_o(db_we), .db_wdata_o(db_wdata)
  );

  biu_regfile #(.NW(NW), .NT(TBL_DEPTH), .ND(ND)) i_regfile (
    .clk_i, .rst_ni,
    .wide_we_i(wide_we), .widx_i(widx), .wide_wdata_i(wide_wdata),
    .tbl_we_i(tbl_we), .tidx_i(tidx), .tbl_wdata_i(tbl_wdata),
    .db_we_i(db_we), .didx_i(didx), .db_wdata_i(db_wdata),
    .live_wide_o(live_wide), .live_tbl_o(live_tbl), .live_db_o(live_db),
    .wide_commit_o, .tbl_commit_o, .db_strobe_o, .db_value_o
  );

  biu_readback i_readback (
    .clk_i, .rst_ni, .rd_i(rd), .kind_i(kind), .size64_i(req_size64_i), .dw_i(dw),
    .live_wide_i(live_wide), .live_tbl_i(live_tbl), .live_db_i(live_db),
    .rsp_valid_o, .rsp_rdata_o
  );

  // R12
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && kind == K_NONE) |=> (wide_commit_o == '0 && tbl_commit_o == '0 && db_strobe_o == '0));

  // R2
  partial_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && kind == K_WIDE && !req_size64_i && dw != 2'd3) |=> (wide_commit_o == '0));
endmodule

// File: tb/test_wide_reg_biu.sv
`timescale 1ns/1ps
module test_wide_reg_biu;
  localparam int AW = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_size64 = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic         req_ready, rsp_valid;
  logic [63:0]  rsp_rdata;
  logic [7:0]   wide_commit;
  logic [15:0]  tbl_commit;
  logic [5:0]   db_strobe;
  logic [191:0] db_value;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [127:0] m_wide [8];
  logic [63:0]  m_tbl  [16];
  logic [31:0]  m_db   [6];
  logic [31:0]  m_col  [3];
  logic [127:0] m_sh;
  logic [7:0]   e_wc;
  logic [15:0]  e_tc;
  logic [5:0]   e_ds;

  always #2 clk = ~clk;

  wide_reg_biu i_wide_reg_biu (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_size64_i(req_size64), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .wide_commit_o(wide_commit), .tbl_commit_o(tbl_commit), .db_strobe_o(db_strobe),
    .db_value_o(db_value)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 wide, 2 table, 3 doorbell
  function automatic void classify(input logic [AW-1:0] a, input bit s64,
                                   output int k, output int idx, output int dw);
    int off = int'(a[12:0]);
    int pg  = int'(a[13]);
    k = 0; idx = 0; dw = 0;
    if (a[1:0] != 2'b00) return;
    if (off < 64) begin
      if (!(s64 && off % 8 == 4)) begin k = 1; idx = pg * 4 + off / 16; dw = (off % 16) / 4; end
    end else if (off >= 'h800 && off < 'h830) begin
      if (off % 16 == 0 && !s64) begin k = 3; idx = pg * 3 + (off - 'h800) / 16; end
    end else if (pg == 0 && off >= 'h1000 && off < 'h1080) begin
      if (!(s64 && off % 8 == 4)) begin k = 2; idx = (off - 'h1000) / 8; dw = (off % 8) / 4; end
    end
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input bit s64, input logic [63:0] d);
    int k, idx, dw;
    classify(a, s64, k, idx, dw);
    e_wc = '0; e_tc = '0; e_ds = '0;
    case (k)
      1: if (s64 && dw == 0) begin m_col[0] = d[31:0]; m_col[1] = d[63:32]; end
         else if (s64) begin m_wide[idx] = {d, m_col[1], m_col[0]}; e_wc[idx] = 1'b1; end
         else if (dw == 3) begin m_wide[idx] = {d[31:0], m_col[2], m_col[1], m_col[0]}; e_wc[idx] = 1'b1; end
         else m_col[dw] = d[31:0];
      2: if (s64) begin m_tbl[idx] = d; e_tc[idx] = 1'b1; end
         else if (dw == 1) begin m_tbl[idx] = {d[31:0], m_col[0]}; e_tc[idx] = 1'b1; end
         else m_col[0] = d[31:0];
      3: begin m_db[idx] = d[31:0]; e_ds[idx] = 1'b1; end
      default: ;
    endcase
  endfunction

  function automatic logic [63:0] model_read(input logic [AW-1:0] a, input bit s64);
    int k, idx, dw;
    logic [63:0] r = '0;
    classify(a, s64, k, idx, dw);
    case (k)
      1: case (dw)
           0: begin m_sh = m_wide[idx]; r = s64 ? m_wide[idx][63:0] : {32'h0, m_wide[idx][31:0]}; end
           1: r = {32'h0, m_sh[63:32]};
           2: r = s64 ? m_sh[127:64] : {32'h0, m_sh[95:64]};
           default: r = {32'h0, m_sh[127:96]};
         endcase
      2: if (dw == 1) r = {32'h0, m_sh[63:32]};
         else begin m_sh = {64'h0, m_tbl[idx]}; r = s64 ? m_tbl[idx] : {32'h0, m_tbl[idx][31:0]}; end
      3: r = {32'h0, m_db[idx]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [191:0] model_db();
    logic [191:0] v;
    for (int i = 0; i < 6; i++) v[i*32 +: 32] = m_db[i];
    return v;
  endfunction

  task automatic bus(input bit wr, input logic [AW-1:0] a, input bit s64, input logic [63:0] d);
    req_valid = 1'b1; req_write = wr; req_size64 = s64; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input bit s64, input logic [63:0] d, input string tag);
    model_write(a, s64, d);
    bus(1'b1, a, s64, d);
    chk({tag, " strobes"}, {226'h0, rsp_valid, wide_commit, tbl_commit, db_strobe},
                           {226'h0, 1'b0, e_wc, e_tc, e_ds});
    chk({tag, " R7 db_value"}, {64'h0, db_value}, {64'h0, model_db()});
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input bit s64, input string tag);
    logic [63:0] e;
    e = model_read(a, s64);
    bus(1'b0, a, s64, 64'h0);
    chk({tag, " R13 rsp"}, {191'h0, rsp_valid, rsp_rdata}, {191'h0, 1'b1, e});
  endtask

  function automatic logic [AW-1:0] wa(input int pg, input int r, input int dw);
    return AW'(pg * 'h2000 + r * 16 + dw * 4);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++)  m_wide[i] = '0;
    for (int i = 0; i < 16; i++) m_tbl[i]  = '0;
    for (int i = 0; i < 6; i++)  m_db[i]   = '0;
    for (int i = 0; i < 3; i++)  m_col[i]  = '0;
    m_sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {32'h0, rsp_valid, wide_commit, tbl_commit, db_strobe, db_value},
                      {32'h0, 1'b0, 8'h0, 16'h0, 6'h0, 192'h0});
    chk("R13 ready", {255'h0, req_ready}, {255'h0, 1'b1});
    do_rd(wa(0, 2, 0), 1'b1, "R1");
    do_rd(wa(0, 2, 3), 1'b0, "R1");

    // R2 partial writes only collect
    do_wr(wa(0, 1, 0), 1'b0, 64'h0000_0000_aaaa_0000, "R2");
    do_wr(wa(0, 1, 1), 1'b0, 64'h0000_0000_aaaa_1111, "R2");
    do_wr(wa(0, 1, 2), 1'b0, 64'h0000_0000_aaaa_2222, "R2");
    do_rd(wa(0, 1, 0), 1'b0, "R2");
    // R3 top dword commits all 128 bits
    do_wr(wa(0, 1, 3), 1'b0, 64'h0000_0000_aaaa_3333, "R3");
    do_rd(wa(0, 1, 0), 1'b0, "R3");
    do_rd(wa(0, 1, 1), 1'b0, "R3");
    do_rd(wa(0, 1, 2), 1'b0, "R3");
    do_rd(wa(0, 1, 3), 1'b0, "R3");

    // R4 and R11: qword writes on page 1
    do_wr(wa(1, 2, 0), 1'b1, 64'h1111_2222_3333_4444, "R4");
    do_wr(wa(1, 2, 2), 1'b1, 64'h5555_6666_7777_8888, "R11");
    do_rd(wa(1, 2, 0), 1'b1, "R11");
    do_rd(wa(1, 2, 2), 1'b1, "R11");

    // R5 shared collector: dword 3 takes slots written for another target
    do_wr(wa(0, 0, 0), 1'b0, 64'h0000_0000_bbbb_0000, "R5");
    do_wr(AW'('h1000 + 8 * 3), 1'b0, 64'h0000_0000_cccc_0000, "R5");
    do_wr(wa(0, 3, 3), 1'b0, 64'h0000_0000_dddd_3333, "R5");
    do_rd(wa(0, 3, 0), 1'b1, "R5");
    do_rd(wa(0, 3, 2), 1'b1, "R5");

    // R6 shadow keeps the dword-0 snapshot while the register changes
    do_rd(wa(0, 1, 0), 1'b0, "R6");
    do_wr(wa(0, 1, 2), 1'b1, 64'hfeed_0003_feed_0002, "R6");
    do_rd(wa(0, 1, 1), 1'b0, "R6");
    do_rd(wa(0, 1, 3), 1'b0, "R6");
    do_rd(wa(0, 1, 0), 1'b1, "R6");

    // R7 doorbell in the middle of a wide write
    do_wr(wa(1, 0, 0), 1'b0, 64'h0000_0000_0101_0000, "R7");
    do_wr(wa(1, 0, 1), 1'b0, 64'h0000_0000_0101_1111, "R7");
    do_wr(AW'('h2000 + 'h820), 1'b0, 64'h0000_0000_0000_0055, "R7");
    do_wr(AW'('h800), 1'b0, 64'h0000_0000_0000_0a0a, "R7");
    do_wr(wa(1, 0, 2), 1'b0, 64'h0000_0000_0101_2222, "R7");
    do_wr(wa(1, 0, 3), 1'b0, 64'h0000_0000_0101_3333, "R7");
    do_rd(wa(1, 0, 0), 1'b1, "R7");
    do_rd(wa(1, 0, 2), 1'b1, "R7");

    // R8 doorbell read leaves shadow alone
    do_rd(wa(0, 3, 0), 1'b0, "R8");
    do_rd(AW'('h2000 + 'h820), 1'b0, "R8");
    do_rd(wa(0, 3, 3), 1'b0, "R8");

    // R9 and R10 table
    do_wr(AW'('h1000 + 8 * 5), 1'b1, 64'h0123_4567_89ab_cdef, "R9");
    do_wr(AW'('h1000 + 8 * 9), 1'b0, 64'h0000_0000_9999_0000, "R9");
    do_wr(AW'('h1000 + 8 * 9 + 4), 1'b0, 64'h0000_0000_9999_1111, "R9");
    do_rd(AW'('h1000 + 8 * 5), 1'b1, "R10");
    do_rd(AW'('h1000 + 8 * 9), 1'b0, "R10");
    do_wr(AW'('h1000 + 8 * 9), 1'b1, 64'h7777_7777_6666_6666, "R10");
    do_rd(AW'('h1000 + 8 * 9 + 4), 1'b0, "R10");

    // R12 ignored accesses
    do_wr(AW'('h2000 + 'h1000), 1'b1, 64'hdead_beef_dead_beef, "R12");
    do_wr(AW'('h0002), 1'b0, 64'hdead_beef_dead_beef, "R12");
    do_wr(wa(0, 1, 1), 1'b1, 64'hdead_beef_dead_beef, "R12");
    do_wr(AW'('h810), 1'b1, 64'hdead_beef_dead_beef, "R12");
    do_wr(AW'('h830), 1'b0, 64'hdead_beef_dead_beef, "R12");
    do_wr(wa(0, 1, 3), 1'b0, 64'h0000_0000_0000_3030, "R12");
    do_rd(wa(0, 1, 0), 1'b1, "R12");
    do_rd(wa(0, 1, 2), 1'b1, "R12");
    do_rd(AW'('h2000 + 'h1000), 1'b1, "R12");
    do_rd(AW'('h0806), 1'b0, "R12");

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      int cat = int'($urandom % 8);
      bit wr  = $urandom % 2 == 1;
      bit s64 = $urandom % 2 == 1;
      logic [63:0] d = {$urandom, $urandom};
      logic [AW-1:0] a;
      string tg;
      case (cat)
        0, 1, 2, 3: begin a = wa(int'($urandom % 2), int'($urandom % 4), int'($urandom % 4)); tg = wr ? "R3" : "R6"; end
        4: begin a = AW'('h1000 + 4 * ($urandom % 32)); tg = wr ? "R9" : "R10"; end
        5: begin a = AW'(($urandom % 2) * 'h2000 + 'h800 + 16 * ($urandom % 3)); s64 = ($urandom % 4 == 0); tg = wr ? "R7" : "R8"; end
        default: begin a = AW'($urandom); tg = "R12"; end
      endcase
      if (wr) do_wr(a, s64, d, tg);
      else    do_rd(a, s64, tg);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule